// File: doc/BRIEF.md
# Quad DAC Serial Command Transmitter

This block sits on the host side of a four-channel 8-bit serial DAC. It takes one command at a time: a 2-bit channel number, a range bit, an 8-bit code and an update mode. From that it produces the four control lines of the converter's serial port: a serial clock, a data line, a load strobe and a global update strobe. The block runs from a fast system clock. Every interval on the serial side is a parameter counted in system-clock cycles: the half period of the serial clock, the setup gap, the load pulse width and the update pulse width. Choosing those counts for the actual system clock keeps the port within the converter's minimum timing.

Two update modes are supported. In immediate mode, the update strobe is held low for the whole frame, so the load pulse moves the new code straight to the selected output. In staged mode, the update strobe stays high, so each frame only fills the channel's holding latch. A separate commit input then sends a lone low pulse on the update strobe, which moves every held code to the outputs in the same instant.

A request is taken only while `busy` is low. `done` is a single-cycle pulse at the end of each operation.

Top module: `qdac_cmd_tx`

## Requirements
- R1: While reset is asserted and right after it is released, `dac_clk` is 0, `dac_load` is 1, `dac_ldac` is 1, `busy` is 0 and `done` is 0.
- R2: A frame is 11 bits, most significant first: channel bit 1, channel bit 0, range bit, then code bits 7 down to 0. Channel 0 is A, 1 is B, 2 is C and 3 is D. Each bit is meant to be captured on a falling edge of `dac_clk`, and exactly 11 falling edges occur per frame.
- R3: Each high phase of `dac_clk` lasts exactly HALF_CYC system cycles. Each low phase between bits lasts at least HALF_CYC cycles. `dac_clk` stays low whenever the block is idle.
- R4: `dac_data` changes only in the cycle where `dac_clk` rises, or while `dac_clk` is low before the first rising edge. It is stable through every high phase and across every falling edge.
- R5: `dac_load` is high at every `dac_clk` edge. The first rising edge of `dac_clk` comes at least SETUP_CYC cycles after the frame starts. `dac_load` falls no sooner than SETUP_CYC cycles after the eleventh falling edge.
- R6: Each frame produces exactly one low pulse on `dac_load`, and that pulse is exactly LOAD_CYC system cycles wide.
- R7: In immediate mode (`req_staged`=0), `dac_ldac` goes low when the request is accepted. It stays low through the load pulse and returns high in the same cycle as `dac_load`. Because this is a falling edge of the update strobe, any staged codes are also released to the outputs.
- R8: In staged mode (`req_staged`=1), `dac_ldac` stays high for the whole frame, so only the channel's holding latch changes.
- R9: A commit drives `dac_ldac` low for exactly LDAC_CYC cycles, with no `dac_clk` or `dac_load` activity, and moves all held codes to the outputs.
- R10: A request or commit is accepted only while `busy` is low. `busy` is high in the cycle after acceptance. A request or commit raised while `busy` is high has no effect.
- R11: `done` is high for exactly one cycle per operation. In that cycle `busy` falls, `dac_load` is high and `dac_ldac` is high. For a frame, this is the cycle where the load pulse ends; for a commit, it is the cycle where the update pulse ends.
- R12: If `req_valid` and `commit` are both high in an idle cycle, the request is taken and the commit is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request, sampled while idle |
| req_chan | input | 2 | Target channel (0=A … 3=D) |
| req_range | input | 1 | Output range bit (0 = ×1, 1 = ×2) |
| req_code | input | 8 | Output code |
| req_staged | input | 1 | 1 = staged write, 0 = immediate update |
| commit | input | 1 | Issue a lone update pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| dac_clk | output | 1 | Serial clock to the converter |
| dac_data | output | 1 | Serial data to the converter |
| dac_load | output | 1 | Load strobe, active low |
| dac_ldac | output | 1 | Global update strobe, active low |

## Verification
Several rules are checked by assertions on every cycle: `dac_load` is high at each serial clock edge, data is steady while the clock is high and across its falling edge, the clock idles low, the update strobe level matches the mode, `done` is one cycle long and aligned, and a concurrent commit is dropped. Some properties only show up when the waveform is decoded, so the bench scenarios cover them. These are the exact high-phase and pulse widths, the 11-bit count, the field order, and which channel ends up with which code after a mix of immediate writes, staged writes and commits. The bench also checks that a second request made while busy leaves no trace on the outputs.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;
  localparam int FRAME_BITS = 11;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_TAIL,
    ST_LOAD,
    ST_LDAC
  } qdac_state_e;

  typedef struct packed {
    logic [1:0] chan;
    logic       rng;
    logic [7:0] code;
  } qdac_frame_t;
endpackage

// File: rtl/qdac_phase_tmr.sv
`timescale 1ns/1ps
module qdac_phase_tmr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (ld)           cnt <= ld_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/qdac_frame_sr.sv
`timescale 1ns/1ps
module qdac_frame_sr #(
  parameter int NBITS = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [NBITS-1:0] frame_in,
  input  logic             shift,
  output logic             serial_out,
  output logic             last_bit
);
  localparam int IDX_W = $clog2(NBITS);

  logic [NBITS-1:0] sr;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (ld) begin
      sr  <= frame_in;
      idx <= '0;
    end else if (shift) begin
      sr  <= {sr[NBITS-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  assign serial_out = sr[NBITS-1];
  assign last_bit   = (idx == IDX_W'(NBITS - 1));

  AST_NO_EXTRA_SHIFT: assert property (@(posedge clk) disable iff (rst)
    shift |-> !last_bit); // R2
endmodule

// File: rtl/qdac_cmd_tx.sv
`timescale 1ns/1ps
module qdac_cmd_tx
  import qdac_pkg::*;
#(
  parameter int HALF_CYC  = 63,
  parameter int SETUP_CYC = 7,
  parameter int LOAD_CYC  = 32,
  parameter int LDAC_CYC  = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_chan,
  input  logic       req_range,
  input  logic [7:0] req_code,
  input  logic       req_staged,
  input  logic       commit,
  output logic       busy,
  output logic       done,
  output logic       dac_clk,
  output logic       dac_data,
  output logic       dac_load,
  output logic       dac_ldac
);
  localparam int MAX_A   = (HALF_CYC > SETUP_CYC) ? HALF_CYC : SETUP_CYC;
  localparam int MAX_B   = (LOAD_CYC > LDAC_CYC) ? LOAD_CYC : LDAC_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] HALF_LD  = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LOAD_LD  = CNT_W'(LOAD_CYC - 1);
  localparam logic [CNT_W-1:0] LDAC_LD  = CNT_W'(LDAC_CYC - 1);

  qdac_state_e      st, nxt;
  logic             staged_q, staged_n;
  logic             tmr_ld, tmr_exp;
  logic [CNT_W-1:0] tmr_val;
  logic             sr_ld, sr_shift, sr_last;
  logic             clk_n, load_n, ldac_n, busy_n, done_n;
  qdac_frame_t      frame_w;

  assign frame_w = '{chan: req_chan, rng: req_range, code: req_code};

  qdac_phase_tmr #(.CNT_W(CNT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .ld      (tmr_ld),
    .ld_val  (tmr_val),
    .expired (tmr_exp)
  );

  qdac_frame_sr #(.NBITS(FRAME_BITS)) u_sr (
    .clk        (clk),
    .rst        (rst),
    .ld         (sr_ld),
    .frame_in   (frame_w),
    .shift      (sr_shift),
    .serial_out (dac_data),
    .last_bit   (sr_last)
  );

  always_comb begin
    nxt      = st;
    tmr_ld   = 1'b0;
    tmr_val  = '0;
    sr_ld    = 1'b0;
    sr_shift = 1'b0;
    clk_n    = dac_clk;
    load_n   = dac_load;
    ldac_n   = dac_ldac;
    busy_n   = busy;
    done_n   = 1'b0;
    staged_n = staged_q;
    case (st)
      ST_IDLE: begin
        if (req_valid) begin
          nxt      = ST_LEAD;
          tmr_ld   = 1'b1;
          tmr_val  = SETUP_LD;
          sr_ld    = 1'b1;
          busy_n   = 1'b1;
          staged_n = req_staged;
          ldac_n   = req_staged;
        end else if (commit) begin
          nxt     = ST_LDAC;
          tmr_ld  = 1'b1;
          tmr_val = LDAC_LD;
          busy_n  = 1'b1;
          ldac_n  = 1'b0;
        end
      end
      ST_LEAD: begin
        if (tmr_exp) begin
          nxt     = ST_HIGH;
          tmr_ld  = 1'b1;
          tmr_val = HALF_LD;
          clk_n   = 1'b1;
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          clk_n  = 1'b0;
          tmr_ld = 1'b1;
          if (sr_last) begin
            nxt     = ST_TAIL;
            tmr_val = SETUP_LD;
          end else begin
            nxt     = ST_LOW;
            tmr_val = HALF_LD;
          end
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          nxt      = ST_HIGH;
          tmr_ld   = 1'b1;
          tmr_val  = HALF_LD;
          clk_n    = 1'b1;
          sr_shift = 1'b1;
        end
      end
      ST_TAIL: begin
        if (tmr_exp) begin
          nxt     = ST_LOAD;
          tmr_ld  = 1'b1;
          tmr_val = LOAD_LD;
          load_n  = 1'b0;
        end
      end
      ST_LOAD: begin
        if (tmr_exp) begin
          nxt    = ST_IDLE;
          load_n = 1'b1;
          ldac_n = 1'b1;
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
      ST_LDAC: begin
        if (tmr_exp) begin
          nxt    = ST_IDLE;
          ldac_n = 1'b1;
          busy_n = 1'b0;
          done_n = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      staged_q <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      dac_clk  <= 1'b0;
      dac_load <= 1'b1;
      dac_ldac <= 1'b1;
    end else begin
      st       <= nxt;
      staged_q <= staged_n;
      busy     <= busy_n;
      done     <= done_n;
      dac_clk  <= clk_n;
      dac_load <= load_n;
      dac_ldac <= ldac_n;
    end
  end

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dac_clk && dac_load)); // R3
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    ($fell(dac_clk) || (dac_clk && $past(dac_clk))) |-> $stable(dac_data)); // R4
  AST_LOAD_HIGH_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    ($rose(dac_clk) || $fell(dac_clk)) |-> (dac_load && $past(dac_load))); // R5
  AST_IMM_LDAC_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy && !staged_q) |-> !dac_ldac); // R7
  AST_STAGED_LDAC_HIGH: assert property (@(posedge clk) disable iff (rst)
    (busy && staged_q && st != ST_LDAC) |-> dac_ldac); // R8
  AST_COMMIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LDAC) |-> (!dac_clk && dac_load && !dac_ldac)); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && $past(req_valid)) |-> (busy && dac_load)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && dac_load && dac_ldac)); // R11
  AST_REQ_OVER_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(busy) && $past(req_valid) && $past(commit)) |-> (st != ST_LDAC)); // R12
endmodule

// File: tb/sim_qdac_cmd_tx.sv
`timescale 1ns/1ps
module sim_qdac_cmd_tx;
  localparam int HALF  = 3;
  localparam int SETUP = 2;
  localparam int LDW   = 4;
  localparam int LDACW = 5;
  localparam int NV    = 9;

  // {op[1:0] (0 imm, 1 staged, 2 commit), chan[1:0], range, code[7:0]}
  localparam logic [12:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b0, 8'hA5},
    {2'd0, 2'd3, 1'b1, 8'h3C},
    {2'd1, 2'd1, 1'b0, 8'h80},
    {2'd1, 2'd2, 1'b1, 8'h7F},
    {2'd2, 2'd0, 1'b0, 8'h00},
    {2'd1, 2'd0, 1'b1, 8'hFF},
    {2'd0, 2'd3, 1'b0, 8'h01},
    {2'd2, 2'd0, 1'b0, 8'h00},
    {2'd0, 2'd1, 1'b0, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_chan = 2'd0;
  logic       req_range = 1'b0;
  logic [7:0] req_code = 8'h00;
  logic       req_staged = 1'b0;
  logic       commit = 1'b0;
  logic       busy, done, dac_clk, dac_data, dac_load, dac_ldac;

  always #4 clk = ~clk; // 8 ns period

  qdac_cmd_tx #(.HALF_CYC(HALF), .SETUP_CYC(SETUP), .LOAD_CYC(LDW), .LDAC_CYC(LDACW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_range(req_range), .req_code(req_code), .req_staged(req_staged),
    .commit(commit), .busy(busy), .done(done), .dac_clk(dac_clk),
    .dac_data(dac_data), .dac_load(dac_load), .dac_ldac(dac_ldac)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model driven only by the serial pins
  logic [8:0]  mout [4];
  logic [8:0]  mlat [4];
  logic [10:0] shreg;
  logic [1:0]  mch;
  logic        pc, pl, pld, load_in_ldac;
  int nbits, hi_run, lo_run, lw, aw, since_fall;
  int n_loadf = 0, n_ldacf = 0, n_done = 0, n_immld = 0;

  initial begin
    for (int i = 0; i < 4; i++) begin
      mout[i] = '0;
      mlat[i] = '0;
    end
  end

  always @(negedge clk) begin
    if (rst) begin
      pc = 1'b0; pl = 1'b1; pld = 1'b1; nbits = 0; hi_run = 0; lo_run = 0;
      lw = 0; aw = 0; since_fall = 0; load_in_ldac = 1'b0; shreg = '0;
    end else begin
      if (!pc && dac_clk) begin
        chk(dac_load, "R5 load high at rise", dac_load, 1);
        if (nbits == 0) chk(lo_run >= SETUP, "R5 lead gap", lo_run, SETUP);
        else            chk(lo_run >= HALF, "R3 low phase", lo_run, HALF);
        lo_run = 0;
      end
      if (pc && !dac_clk) begin
        chk(dac_load, "R5 load high at fall", dac_load, 1);
        chk(hi_run == HALF, "R3 high phase", hi_run, HALF);
        shreg = {shreg[9:0], dac_data};
        nbits++;
        hi_run = 0;
        since_fall = 0;
      end else begin
        since_fall++;
      end
      if (dac_clk) hi_run++;
      else if (busy) lo_run++;
      if (!busy) lo_run = 0;

      if (pld && !dac_ldac) begin
        n_ldacf++;
        for (int i = 0; i < 4; i++) mout[i] = mlat[i];
        aw = 0;
        load_in_ldac = 1'b0;
      end
      if (pl && !dac_load) begin
        n_loadf++;
        chk(nbits == 11, "R2 bits per frame", nbits, 11);
        chk(since_fall >= SETUP, "R5 tail gap", since_fall, SETUP);
        mch = shreg[10:9];
        mlat[mch] = shreg[8:0];
        if (!dac_ldac) begin
          n_immld++;
          mout[mch] = shreg[8:0];
        end
        nbits = 0;
        lw = 0;
        load_in_ldac = 1'b1;
      end
      if (!pl && dac_load) chk(lw == LDW, "R6 load width", lw, LDW);
      if (!dac_load) lw++;
      if (!pld && dac_ldac && !load_in_ldac) chk(aw == LDACW, "R9 ldac width", aw, LDACW);
      if (!dac_ldac) aw++;
      if (done) begin
        n_done++;
        chk(dac_load && dac_ldac && !busy, "R11 done alignment",
            {dac_load, dac_ldac, busy}, 3'b110);
      end
      pc = dac_clk; pl = dac_load; pld = dac_ldac;
    end
  end

  logic [8:0] eout [4];
  logic [8:0] elat [4];

  task automatic wait_done();
    int w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
    end
    chk(done, "R11 done seen", done, 1);
    @(negedge clk);
  endtask

  task automatic check_outputs(input string tag);
    for (int i = 0; i < 4; i++) chk(mout[i] == eout[i], tag, mout[i], eout[i]);
  endtask

  task automatic do_op(input logic [1:0] op, input logic [1:0] ch, input logic rng, input logic [7:0] code);
    int b_load, b_ldac, b_done, b_imm;
    logic [8:0] v;
    while (busy) @(negedge clk);
    b_load = n_loadf; b_ldac = n_ldacf; b_done = n_done; b_imm = n_immld;
    v = {rng, code};
    if (op == 2'd2) commit = 1'b1;
    else begin
      req_valid = 1'b1; req_chan = ch; req_range = rng; req_code = code;
      req_staged = (op == 2'd1);
    end
    @(negedge clk);
    req_valid = 1'b0; commit = 1'b0;
    chk(busy, "R10 busy after accept", busy, 1);
    wait_done();
    case (op)
      2'd0: begin
        for (int i = 0; i < 4; i++) eout[i] = elat[i];
        elat[ch] = v; eout[ch] = v;
        chk(n_immld - b_imm == 1, "R7 ldac low at load", n_immld - b_imm, 1);
        chk(n_loadf - b_load == 1, "R6 one load pulse", n_loadf - b_load, 1);
      end
      2'd1: begin
        elat[ch] = v;
        chk(n_ldacf - b_ldac == 0, "R8 ldac stayed high", n_ldacf - b_ldac, 0);
        chk(n_loadf - b_load == 1, "R6 one load pulse", n_loadf - b_load, 1);
      end
      default: begin
        for (int i = 0; i < 4; i++) eout[i] = elat[i];
        chk(n_loadf - b_load == 0, "R9 no load on commit", n_loadf - b_load, 0);
        chk(n_ldacf - b_ldac == 1, "R9 one update pulse", n_ldacf - b_ldac, 1);
      end
    endcase
    chk(n_done - b_done == 1, "R11 single done", n_done - b_done, 1);
    check_outputs("R2 channel output");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int b_done, b_ldac, b_load;
    for (int i = 0; i < 4; i++) begin
      eout[i] = '0;
      elat[i] = '0;
    end
    repeat (5) @(negedge clk);
    chk(!dac_clk && dac_load && dac_ldac && !busy && !done, "R1 state in reset",
        {dac_clk, dac_load, dac_ldac, busy, done}, 5'b01100);
    rst = 1'b0;
    @(negedge clk);
    chk(!dac_clk && dac_load && dac_ldac && !busy && !done, "R1 state after reset",
        {dac_clk, dac_load, dac_ldac, busy, done}, 5'b01100);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][12:11], VEC[i][10:9], VEC[i][8], VEC[i][7:0]);

    // R10: request and commit raised while busy are ignored
    b_load = n_loadf; b_done = n_done;
    req_valid = 1'b1; req_chan = 2'd1; req_range = 1'b0; req_code = 8'h11; req_staged = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R10 busy mid frame", busy, 1);
    req_valid = 1'b1; req_chan = 2'd1; req_code = 8'hEE; commit = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; commit = 1'b0;
    wait_done();
    for (int i = 0; i < 4; i++) eout[i] = elat[i];
    elat[1] = 9'h011; eout[1] = 9'h011;
    chk(mout[1] == 9'h011, "R10 busy request ignored", mout[1], 9'h011);
    repeat (20) @(negedge clk);
    chk(!busy && n_loadf - b_load == 1 && n_done - b_done == 1, "R10 no second operation",
        n_done - b_done, 1);
    check_outputs("R10 outputs");

    // R12: request and commit in the same idle cycle
    b_ldac = n_ldacf; b_done = n_done;
    req_valid = 1'b1; req_chan = 2'd2; req_range = 1'b0; req_code = 8'h5A; req_staged = 1'b1;
    commit = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; commit = 1'b0;
    wait_done();
    elat[2] = 9'h05A;
    chk(n_ldacf - b_ldac == 0, "R12 commit dropped, no update pulse", n_ldacf - b_ldac, 0);
    repeat (20) @(negedge clk);
    chk(!busy && n_done - b_done == 1, "R12 only the request ran", n_done - b_done, 1);
    check_outputs("R12 outputs held");
    do_op(2'd2, 2'd0, 1'b0, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule